// File: doc/BRIEF.md
# Key-Protected Configuration Registers for an Ethernet Media-Interface Converter

This block holds the configuration of a multi-port Ethernet media-interface converter behind a simple 32-bit register bus. The bus has a write strobe, a word address, write data and a read-data path that is combinational from the address. The stored fields drive the converter directly through output pins: the port-mux mode, each port's interface mode, speed and full-duplex flag, each port's run-enable, and two switch speed/duplex control words.

Every configuration register is write-protected. Software first writes a fixed four-word key to the command register at offset 0x000. Until that key has arrived in order, writes to every other register are dropped. Reads are never gated. Writing zero to the command register closes the bank again. Four status bits per port come from input pins and show up in that port's control register as read-only bits.

Top module: `mii_conv_cfg_bank`

## Requirements
- R1: Reset (asynchronous, active low) clears every stored field and every output to zero and leaves the bank closed, so a configuration write made just after reset has no effect.
- R2: While the bank is closed, a write to any configuration register is dropped. Reads still return the stored value.
- R3: The bank opens after four consecutive command-register writes (offset 0x000) of 0x000000A5, 0x00000001, 0x0000FFFE and 0x00000001. From the next cycle on, configuration writes take effect.
- R4: A command write that does not match the expected key word sends the key checker back to its first step, so the attempt fails. If that write is 0x000000A5, it counts as the first word of a new attempt.
- R5: Writing 0x00000000 to the command register closes the bank. Other non-key command writes leave an open bank open.
- R6: The mode register at offset 0x008 stores bits MODE_W-1:0 (default 4:0) and drives `mux_mode`. Its other bits read as zero.
- R7: Port p's control register is at offset 0x100 + 4·p. Bits 1:0 are the speed (0 = 10, 1 = 100, 2 = 1000 Mb/s), bits 3:2 the interface mode (0 = MII, 1 = RMII, 2 = RGMII) and bit 8 the full-duplex flag, driven on `port_speed`, `port_ifmode` and `port_full_dup` at bit position 2·p (or p). The other writable-looking bits read as zero.
- R8: Bits 15:12 of port p's control register read `link_stat_in[4p+3:4p]` (12 = link, 13 = duplex, 15:14 = speed). Bus writes to those bits are ignored.
- R9: The run register at offset 0x114 stores one bit per port in bits NUM_PORTS-1:0. A set bit drives `port_run[p]` high and releases that port's converter.
- R10: The switch speed-control and duplex-control registers at offsets 0x304 and 0x308 store bits SW_W-1:0 (default 15:0) and drive `sw_speed_ctl` and `sw_dup_ctl`.
- R11: Offset 0x004 reads the constant ID_VALUE (default 0x00000C51). The command register and unmapped offsets read zero, and writes to them store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of a 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| link_stat_in | input | 4·NUM_PORTS | Per-port status bits shown in control bits 15:12 |
| mux_mode | output | MODE_W | Port-mux mode field |
| port_speed | output | 2·NUM_PORTS | Per-port speed code |
| port_ifmode | output | 2·NUM_PORTS | Per-port interface mode code |
| port_full_dup | output | NUM_PORTS | Per-port full-duplex flag |
| port_run | output | NUM_PORTS | Per-port converter run-enable |
| sw_speed_ctl | output | SW_W | Switch speed-control word |
| sw_dup_ctl | output | SW_W | Switch duplex-control word |

## Verification
The bench targets the key checker's edges. It sends a broken key with a wrong third word, then a retry that repeats 0x000000A5 in mid-sequence. A checker that does not restart on the repeated word would stay closed. A checker that does not reset on a mismatch would open early. It checks that a non-zero non-key command write leaves the bank open and that a zero write shuts it. A design that closes on any command write, or ignores the zero, would show the wrong mode value on read-back. It also drives the status pins behind a port register and writes ones over those bits. A design that stored bus data there would return the written bits instead of the pins.

// File: rtl/mii_conv_cfg_pkg.sv
package mii_conv_cfg_pkg;

  localparam int OFF_CMD   = 'h000;
  localparam int OFF_ID    = 'h004;
  localparam int OFF_MODE  = 'h008;
  localparam int OFF_PORT  = 'h100;
  localparam int OFF_RUN   = 'h114;
  localparam int OFF_SWSPD = 'h304;
  localparam int OFF_SWDUP = 'h308;

  localparam logic [31:0] KEY_W0 = 32'h0000_00A5;
  localparam logic [31:0] KEY_W1 = 32'h0000_0001;
  localparam logic [31:0] KEY_W2 = 32'h0000_FFFE;
  localparam logic [31:0] KEY_W3 = 32'h0000_0001;
  localparam logic [31:0] CLOSE_WORD = 32'h0000_0000;

  localparam int KEY_LEN = 4;
  localparam int STEP_W  = $clog2(KEY_LEN);

  function automatic logic [31:0] key_word(input logic [STEP_W-1:0] step);
    case (step)
      2'd0:    return KEY_W0;
      2'd1:    return KEY_W1;
      2'd2:    return KEY_W2;
      default: return KEY_W3;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
  import mii_conv_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_data,
  output logic        bank_open
);

  logic [STEP_W-1:0] step_q;
  logic              open_q;
  logic              is_match;
  logic              is_last;

  assign is_match  = (cmd_data == key_word(step_q));
  assign is_last   = (step_q == STEP_W'(KEY_LEN - 1));
  assign bank_open = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      open_q <= 1'b0;
    end else if (cmd_wr) begin
      if (cmd_data == CLOSE_WORD) begin
        open_q <= 1'b0;
        step_q <= '0;
      end else if (is_match) begin
        if (is_last) begin
          open_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else begin
        // a mismatch restarts; the first key word starts a new attempt
        step_q <= (cmd_data == KEY_W0) ? STEP_W'(1) : '0;
      end
    end
  end

endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_speed,
  input  logic [1:0]  wr_ifmode,
  input  logic        wr_fdup,
  input  logic [3:0]  stat_in,
  output logic [1:0]  speed,
  output logic [1:0]  ifmode,
  output logic        full_dup,
  output logic [31:0] rd_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed    <= '0;
      ifmode   <= '0;
      full_dup <= 1'b0;
    end else if (wr_en) begin
      speed    <= wr_speed;
      ifmode   <= wr_ifmode;
      full_dup <= wr_fdup;
    end
  end

  always_comb begin
    rd_word        = '0;
    rd_word[1:0]   = speed;
    rd_word[3:2]   = ifmode;
    rd_word[8]     = full_dup;
    rd_word[15:12] = stat_in;
  end

endmodule

// File: rtl/mii_conv_cfg_bank.sv
module mii_conv_cfg_bank
  import mii_conv_cfg_pkg::*;
#(
  parameter int          NUM_PORTS = 5,
  parameter int          MODE_W    = 5,
  parameter int          SW_W      = 16,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] ID_VALUE  = 32'h0000_0C51
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [4*NUM_PORTS-1:0] link_stat_in,
  output logic [MODE_W-1:0]      mux_mode,
  output logic [2*NUM_PORTS-1:0] port_speed,
  output logic [2*NUM_PORTS-1:0] port_ifmode,
  output logic [NUM_PORTS-1:0]   port_full_dup,
  output logic [NUM_PORTS-1:0]   port_run,
  output logic [SW_W-1:0]        sw_speed_ctl,
  output logic [SW_W-1:0]        sw_dup_ctl
);

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(OFF_RUN);
  localparam logic [ADDR_W-1:0] A_SWSPD = ADDR_W'(OFF_SWSPD);
  localparam logic [ADDR_W-1:0] A_SWDUP = ADDR_W'(OFF_SWDUP);

  logic                 wr_open;
  logic                 cmd_wr;
  logic                 cfg_wr;
  logic [NUM_PORTS-1:0] hit_port;
  logic [31:0]          port_word [NUM_PORTS];
  logic [MODE_W-1:0]    mode_q;
  logic [NUM_PORTS-1:0] run_q;
  logic [SW_W-1:0]      swspd_q;
  logic [SW_W-1:0]      swdup_q;

  assign cmd_wr = bus_wr && (bus_addr == A_CMD);
  assign cfg_wr = bus_wr && wr_open;

  cfg_key_unlock u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_data  (bus_wdata),
    .bank_open (wr_open)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign hit_port[p] = (bus_addr == ADDR_W'(OFF_PORT + 4 * p));

    cfg_port_regs u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr && hit_port[p]),
      .wr_speed  (bus_wdata[1:0]),
      .wr_ifmode (bus_wdata[3:2]),
      .wr_fdup   (bus_wdata[8]),
      .stat_in   (link_stat_in[4*p +: 4]),
      .speed     (port_speed[2*p +: 2]),
      .ifmode    (port_ifmode[2*p +: 2]),
      .full_dup  (port_full_dup[p]),
      .rd_word   (port_word[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      run_q   <= '0;
      swspd_q <= '0;
      swdup_q <= '0;
    end else if (cfg_wr) begin
      if (bus_addr == A_MODE)  mode_q  <= bus_wdata[MODE_W-1:0];
      if (bus_addr == A_RUN)   run_q   <= bus_wdata[NUM_PORTS-1:0];
      if (bus_addr == A_SWSPD) swspd_q <= bus_wdata[SW_W-1:0];
      if (bus_addr == A_SWDUP) swdup_q <= bus_wdata[SW_W-1:0];
    end
  end

  assign mux_mode     = mode_q;
  assign port_run     = run_q;
  assign sw_speed_ctl = swspd_q;
  assign sw_dup_ctl   = swdup_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ID)    bus_rdata = ID_VALUE;
    if (bus_addr == A_MODE)  bus_rdata[MODE_W-1:0]    = mode_q;
    if (bus_addr == A_RUN)   bus_rdata[NUM_PORTS-1:0] = run_q;
    if (bus_addr == A_SWSPD) bus_rdata[SW_W-1:0]      = swspd_q;
    if (bus_addr == A_SWDUP) bus_rdata[SW_W-1:0]      = swdup_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit_port[p]) bus_rdata = port_word[p];
    end
  end

endmodule

// File: rtl/mii_conv_cfg_bank_chk.sv
module mii_conv_cfg_bank_chk
  import mii_conv_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int MODE_W    = 5,
  parameter int ADDR_W    = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [4*NUM_PORTS-1:0] link_stat_in,
  input logic                   wr_open,
  input logic [MODE_W-1:0]      mux_mode,
  input logic [NUM_PORTS-1:0]   port_run
);

  // R2: a closed bank keeps the mode field
  p_closed_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_open |=> $stable(mux_mode));

  // R2, R9: a closed bank keeps the run bits
  p_closed_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_open |=> $stable(port_run));

  // R3: the bank opens only on the final key word
  p_open_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_open) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata == KEY_W3));

  // R5: a zero command write closes the bank
  p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata == CLOSE_WORD) |=> !wr_open);

  // R5: nothing but the zero word closes an open bank
  p_stay_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_open && !(bus_wr && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata == CLOSE_WORD)) |=> wr_open);

  // R8: port 0 status bits come from the pins
  p_stat_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_PORT)) |-> (bus_rdata[15:12] == link_stat_in[3:0]));

endmodule

bind mii_conv_cfg_bank mii_conv_cfg_bank_chk #(
  .NUM_PORTS (NUM_PORTS),
  .MODE_W    (MODE_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .link_stat_in (link_stat_in),
  .wr_open      (wr_open),
  .mux_mode     (mux_mode),
  .port_run     (port_run)
);

// File: tb/mii_conv_cfg_bank_tb.sv
module mii_conv_cfg_bank_tb;

  localparam int NP = 5;
  localparam int MW = 5;
  localparam int SW = 16;
  localparam int AW = 12;
  localparam logic [31:0] ID_EXP = 32'h0000_0C51;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [4*NP-1:0] link_stat_in = '0;
  logic [MW-1:0]   mux_mode;
  logic [2*NP-1:0] port_speed, port_ifmode;
  logic [NP-1:0]   port_full_dup, port_run;
  logic [SW-1:0]   sw_speed_ctl, sw_dup_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mii_conv_cfg_bank u_dut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .link_stat_in (link_stat_in),
    .mux_mode (mux_mode), .port_speed (port_speed), .port_ifmode (port_ifmode),
    .port_full_dup (port_full_dup), .port_run (port_run),
    .sw_speed_ctl (sw_speed_ctl), .sw_dup_ctl (sw_dup_ctl)
  );

  // entry: {kind(0 write,1 read-check), req, addr, data}
  localparam int TN = 30;
  localparam logic [49:0] TBL [TN] = '{
    {2'd0, 4'd2,  12'h008, 32'h0000_001F},
    {2'd1, 4'd2,  12'h008, 32'h0000_0000},
    {2'd0, 4'd2,  12'h114, 32'h0000_001F},
    {2'd1, 4'd2,  12'h114, 32'h0000_0000},
    {2'd0, 4'd3,  12'h000, 32'h0000_00A5},
    {2'd0, 4'd3,  12'h000, 32'h0000_0001},
    {2'd0, 4'd3,  12'h000, 32'h0000_FFFE},
    {2'd0, 4'd3,  12'h000, 32'h0000_0001},
    {2'd0, 4'd6,  12'h008, 32'hFFFF_FFF3},
    {2'd1, 4'd6,  12'h008, 32'h0000_0013},
    {2'd0, 4'd7,  12'h100, 32'hFFFF_FFFF},
    {2'd1, 4'd7,  12'h100, 32'h0000_010F},
    {2'd0, 4'd7,  12'h104, 32'h0000_0006},
    {2'd1, 4'd7,  12'h104, 32'h0000_0006},
    {2'd0, 4'd9,  12'h114, 32'hFFFF_FFEA},
    {2'd1, 4'd9,  12'h114, 32'h0000_000A},
    {2'd0, 4'd10, 12'h304, 32'h0000_1234},
    {2'd1, 4'd10, 12'h304, 32'h0000_1234},
    {2'd0, 4'd10, 12'h308, 32'hFFFF_BEEF},
    {2'd1, 4'd10, 12'h308, 32'h0000_BEEF},
    {2'd0, 4'd5,  12'h000, 32'h0000_0007},
    {2'd0, 4'd5,  12'h008, 32'h0000_0005},
    {2'd1, 4'd5,  12'h008, 32'h0000_0005},
    {2'd0, 4'd5,  12'h000, 32'h0000_0000},
    {2'd0, 4'd5,  12'h008, 32'h0000_001A},
    {2'd1, 4'd5,  12'h008, 32'h0000_0005},
    {2'd1, 4'd11, 12'h004, 32'h0000_0C51},
    {2'd1, 4'd11, 12'h000, 32'h0000_0000},
    {2'd0, 4'd11, 12'h200, 32'h0000_FFFF},
    {2'd1, 4'd11, 12'h200, 32'h0000_0000}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mux_mode", 32'(mux_mode), 32'h0);
    check("R1 port_run", 32'(port_run), 32'h0);
    rst_n = 1'b1;
    read_check("R1 mode readback", 12'h008, 32'h0);

    for (int i = 0; i < TN; i++) begin
      if (TBL[i][49:48] == 2'd0)
        bus_write(TBL[i][43:32], TBL[i][31:0]);
      else
        read_check(req_name(TBL[i][47:44]), TBL[i][43:32], TBL[i][31:0]);
    end

    // R6, R7, R9, R10: output pins
    check("R6 mux_mode pin", 32'(mux_mode), 32'h05);
    check("R7 port_speed pin", 32'(port_speed[3:0]), 32'h B);
    check("R7 port_ifmode pin", 32'(port_ifmode[3:0]), 32'h7);
    check("R7 port_full_dup pin", 32'(port_full_dup), 32'h01);
    check("R9 port_run pin", 32'(port_run), 32'h0A);
    check("R10 sw_speed_ctl pin", 32'(sw_speed_ctl), 32'h1234);
    check("R10 sw_dup_ctl pin", 32'(sw_dup_ctl), 32'hBEEF);

    // R4: wrong third word aborts the attempt
    bus_write(12'h000, 32'h0000_00A5);
    bus_write(12'h000, 32'h0000_0001);
    bus_write(12'h000, 32'h0000_FFFF);
    bus_write(12'h000, 32'h0000_FFFE);
    bus_write(12'h000, 32'h0000_0001);
    bus_write(12'h008, 32'h0000_0011);
    read_check("R4 broken key stays closed", 12'h008, 32'h05);

    // R4: a repeated first word restarts the attempt
    bus_write(12'h000, 32'h0000_00A5);
    bus_write(12'h000, 32'h0000_00A5);
    bus_write(12'h000, 32'h0000_0001);
    bus_write(12'h000, 32'h0000_FFFE);
    bus_write(12'h000, 32'h0000_0001);
    bus_write(12'h008, 32'h0000_0011);
    read_check("R4 restarted key opens", 12'h008, 32'h11);

    // R8: status bits come from pins, writes to them ignored
    link_stat_in[11:8] = 4'hB;
    read_check("R8 status pins", 12'h108, 32'h0000_B000);
    bus_write(12'h108, 32'h0000_F000);
    link_stat_in[11:8] = 4'h3;
    read_check("R8 status write ignored", 12'h108, 32'h0000_3000);

    // R1: reset mid-run clears and closes
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mux_mode after reset", 32'(mux_mode), 32'h0);
    check("R1 port_run after reset", 32'(port_run), 32'h0);
    check("R1 sw_speed_ctl after reset", 32'(sw_speed_ctl), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_write(12'h008, 32'h0000_001F);
    read_check("R1 closed after reset", 12'h008, 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule